// File: doc/BRIEF.md
# HI/LO Multiply-Accumulate Unit

This unit holds a 64-bit accumulator split into two 32-bit halves, HI (upper) and LO (lower), and updates it from the product of two 32-bit operands. A three-bit operation code picks between plain multiply, multiply-add and multiply-subtract, each in a signed and an unsigned form. The plain forms overwrite the pair with the product. The accumulating forms add the product to the current pair, or subtract it, and write the outcome back.

A caller presents the operands and the operation code together with a one-cycle start strobe. The updated pair and a one-cycle done strobe appear in the following cycle. A separate write port loads both halves directly, so a test or a context restore can seed the accumulator before a chain of accumulating operations.

Top module: `hilo_mac`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) sets HI and LO to zero and holds done low.
- R2: Operation code 0 (signed multiply) treats both operands as two's-complement values and writes the 64-bit product, upper word to HI and lower word to LO.
- R3: Operation code 1 (unsigned multiply) treats both operands as unsigned values and writes the 64-bit product, upper word to HI and lower word to LO.
- R4: Operation codes 2 (signed) and 3 (unsigned) write {HI,LO} plus the product of the operands, the product formed as in R2 and R3 respectively.
- R5: Operation codes 4 (signed) and 5 (unsigned) write {HI,LO} minus the product of the operands, the product formed as in R2 and R3 respectively.
- R6: Accumulation wraps modulo 2^64; no saturation and no overflow indication.
- R7: A start accepted at a clock edge makes the new HI and LO visible after that edge, and done is high for exactly the one cycle after that edge.
- R8: Operation codes 6 and 7 leave HI and LO unchanged; done still pulses.
- R9: With wr_en high at a clock edge, HI and LO take wr_hi and wr_lo; a start in the same cycle is ignored and done stays low.
- R10: With neither start nor wr_en, HI and LO hold their values and done is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to run the selected operation |
| op | input | 3 | Operation code (0..5 valid) |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| wr_en | input | 1 | Direct load of HI and LO |
| wr_hi | input | 32 | Value loaded into HI |
| wr_lo | input | 32 | Value loaded into LO |
| done | output | 1 | High for one cycle after an accepted start |
| hi | output | 32 | Upper accumulator word |
| lo | output | 32 | Lower accumulator word |

## Verification
The bench aims at operands with the top bit set, where a design that mixed up sign and zero extension would return a wrong HI word (for example all-ones times all-ones giving 1 instead of FFFFFFFE_00000001). It preloads the pair near the 64-bit limits so that a wrongly sized or saturating accumulator would fail to wrap on multiply-add and multiply-subtract. It sends the unused codes 6 and 7, which a design with a loose decode would treat as an accumulate, and collides a direct write with a start to catch a wrong priority. Random operations over random preloads then compare every result with a model built on 64-bit integer arithmetic.

// File: rtl/hilo_mac.sv
module hilo_mac #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         wr_en,
  input  logic [W-1:0] wr_hi,
  input  logic [W-1:0] wr_lo,
  output logic         done,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  localparam int W2 = 2 * W;

  logic          is_signed;
  logic          op_valid;
  logic [W2-1:0] ext_a, ext_b, prod, acc, next_acc;

  assign is_signed = ~op[0];
  assign op_valid  = (op <= 3'd5);
  assign ext_a     = {{W{is_signed & a[W-1]}}, a};
  assign ext_b     = {{W{is_signed & b[W-1]}}, b};
  assign prod      = ext_a * ext_b;
  assign acc       = {hi, lo};

  always_comb begin
    case (op[2:1])
      2'd0:    next_acc = prod;
      2'd1:    next_acc = acc + prod;
      2'd2:    next_acc = acc - prod;
      default: next_acc = acc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi   <= '0;
      lo   <= '0;
      done <= 1'b0;
    end else if (wr_en) begin
      hi   <= wr_hi;
      lo   <= wr_lo;
      done <= 1'b0;
    end else begin
      done <= start;
      if (start && op_valid) begin
        hi <= next_acc[W2-1:W];
        lo <= next_acc[W-1:0];
      end
    end
  end

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst) (start && !wr_en) |=> done); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) !(start && !wr_en) |=> !done); // R7
  AST_BAD_OP_HOLD: assert property (@(posedge clk) disable iff (rst) (start && !wr_en && op > 3'd5) |=> ($stable(hi) && $stable(lo))); // R8
  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (rst) wr_en |=> (hi == $past(wr_hi) && lo == $past(wr_lo) && !done)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (!start && !wr_en) |=> ($stable(hi) && $stable(lo))); // R10
endmodule

// File: tb/hilo_mac_bench.sv
module hilo_mac_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_hi = '0, wr_lo = '0;
  logic        done;
  logic [31:0] hi, lo;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] mdl = '0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hilo_mac u_hilo_mac (
    .clk(clk), .rst(rst), .start(start), .op(op), .a(a), .b(b),
    .wr_en(wr_en), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .done(done), .hi(hi), .lo(lo)
  );

  function automatic logic [63:0] model(input logic [2:0] code, input logic [31:0] x,
                                        input logic [31:0] y, input logic [63:0] cur);
    longint s_p;
    longint unsigned u_p;
    s_p = longint'($signed(x)) * longint'($signed(y));
    u_p = longint'({32'd0, x}) * longint'({32'd0, y});
    case (code)
      3'd0: return 64'(s_p);
      3'd1: return 64'(u_p);
      3'd2: return cur + 64'(s_p);
      3'd3: return cur + 64'(u_p);
      3'd4: return cur - 64'(s_p);
      3'd5: return cur - 64'(u_p);
      default: return cur;
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%016h expected=%016h", req, act, exp);
    end
  endtask

  task automatic preload(input logic [63:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_hi = v[63:32]; wr_lo = v[31:0];
    @(negedge clk);
    wr_en = 1'b0;
    mdl = v;
    chk("R9 preload", {hi, lo}, v);
    chk("R9 done low on write", {63'd0, done}, 64'd0);
  endtask

  task automatic run(input string req, input logic [2:0] code, input logic [31:0] x, input logic [31:0] y);
    @(negedge clk);
    start = 1'b1; op = code; a = x; b = y;
    @(negedge clk);
    start = 1'b0;
    mdl = model(code, x, y, mdl);
    chk({req, " result"}, {hi, lo}, mdl);
    chk("R7 done pulse", {63'd0, done}, 64'd1);
    @(negedge clk);
    chk("R7 done single cycle", {63'd0, done}, 64'd0);
    chk("R10 hold", {hi, lo}, mdl);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    chk("R1 reset value", {hi, lo}, 64'd0);
    chk("R1 reset done", {63'd0, done}, 64'd0);
    rst = 1'b0;

    run("R2 neg*neg", 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk("R2 value", mdl, 64'd1);
    run("R2 min*min", 3'd0, 32'h8000_0000, 32'h8000_0000);
    chk("R2 value", mdl, 64'h4000_0000_0000_0000);
    run("R2 neg*pos", 3'd0, 32'hFFFF_FFFF, 32'd1);
    chk("R2 value", mdl, 64'hFFFF_FFFF_FFFF_FFFF);
    run("R3 max*max", 3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk("R3 value", mdl, 64'hFFFF_FFFE_0000_0001);

    preload(64'h0000_0001_0000_0000);
    run("R4 signed add", 3'd2, 32'hFFFF_FFFF, 32'd2);
    chk("R4 value", mdl, 64'h0000_0000_FFFF_FFFE);
    preload(64'hFFFF_FFFF_FFFF_FFFF);
    run("R6 R4 unsigned add wrap", 3'd3, 32'd1, 32'd1);
    chk("R6 wrap value", mdl, 64'd0);
    preload(64'd0);
    run("R6 R5 unsigned sub wrap", 3'd5, 32'd1, 32'd1);
    chk("R6 wrap value", mdl, 64'hFFFF_FFFF_FFFF_FFFF);
    preload(64'd5);
    run("R5 signed sub", 3'd4, 32'hFFFF_FFFE, 32'd3);
    chk("R5 value", mdl, 64'd11);

    preload(64'h1234_5678_9ABC_DEF0);
    run("R8 code 6", 3'd6, 32'd7, 32'd9);
    run("R8 code 7", 3'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk("R8 unchanged", mdl, 64'h1234_5678_9ABC_DEF0);

    @(negedge clk);
    wr_en = 1'b1; wr_hi = 32'hCAFE_0001; wr_lo = 32'h0BAD_F00D;
    start = 1'b1; op = 3'd0; a = 32'd3; b = 32'd3;
    @(negedge clk);
    wr_en = 1'b0; start = 1'b0;
    mdl = 64'hCAFE_0001_0BAD_F00D;
    chk("R9 write beats start", {hi, lo}, mdl);
    chk("R9 no done on collision", {63'd0, done}, 64'd0);

    @(negedge clk); a = 32'h5555_5555; b = 32'hAAAA_AAAA; op = 3'd2;
    repeat (4) @(negedge clk);
    chk("R10 idle hold", {hi, lo}, mdl);

    for (int i = 0; i < 300; i++) begin
      if (i % 10 == 0) preload({$urandom, $urandom});
      run("R2 R3 R4 R5 random", 3'($urandom_range(0, 7)), $urandom, $urandom);
    end

    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 reset again", {hi, lo}, 64'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule